// File: doc/BRIEF.md
# Trace-Driven Cache Statistics Model

This block watches a stream of memory references and keeps hit, miss and eviction counts for a modelled two-level cache hierarchy. It stores no data. It holds only tag, valid and replacement state. Each reference carries an address, a read/write flag, an instruction/data flag and a context number. The reference is looked up in a private first-level tag array that belongs to its context and side (instruction or data). When it misses there, it is passed one cycle later to a shared second-level tag array.

Both levels are set-associative with a configurable number of ways. Both use tree pseudo-LRU replacement. All statistics counters update while the stream runs. A one-cycle read port lets a monitor sample any counter at any time. A clear command zeroes the counters and leaves the cached tags as they are, so statistics can be restarted mid-run without disturbing the warm cache state.

Top module: `trace_cache_stats`

## Requirements
- R1: An address is split into a line offset (log2 of LINE_B bits), a set index above it, and a tag above the index. A reference hits only if its tag is valid in the selected set of the first-level array for its own context and its own side. Instruction references (ref_instr=1) use the instruction side and data references use the data side.
- R2: Each valid reference adds exactly one to either the hit counter or the miss counter of its context and side. It also adds one to the total-reference counter.
- R3: On a miss, the line fills the lowest-numbered invalid way of the set. If every way is valid, the line replaces the pseudo-LRU victim, and the eviction counter of that level and side increments only in that case.
- R4: Replacement uses a binary tree with WAYS-1 bits per set. Node 1 is the root, and the children of node n are 2n and 2n+1. A bit value of 1 points the victim walk to the right child. Every hit or fill sets each node on the accessed way's path so that it points away from that way.
- R5: A first-level miss is presented to the shared second-level array in the following clock cycle. There it produces exactly one second-level hit or miss count, fills by the same rules, and counts second-level evictions.
- R6: Writes are looked up, filled and counted exactly like reads (write-allocate).
- R7: Every counter is CW bits wide and holds at its all-ones value instead of wrapping.
- R8: A one-cycle pulse on clr_stats zeroes every counter on the next clock edge and leaves all tag, valid and replacement state unchanged.
- R9: Synchronous reset zeroes every counter, marks every line of both levels invalid and clears all replacement bits.
- R10: rd_data is registered and shows, one clock after rd_addr is applied, the counter at that address. Addresses ctx*4+k hold the per-context counters: k=0 instruction hits, k=1 instruction misses, k=2 data hits, k=3 data misses. Address 4*NCTX+g holds the global counters: g=0 references, g=1 instruction-side evictions, g=2 data-side evictions, g=3 second-level hits, g=4 second-level misses, g=5 second-level evictions. Any higher address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_addr | input | ADDR_W | Byte address of the reference |
| ref_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| ref_write | input | 1 | 1 = store; handled the same as a load |
| ref_ctx | input | CTX_W | Context issuing the reference |
| clr_stats | input | 1 | Zero all counters, keep cache state |
| rd_addr | input | RD_AW | Counter select for the read port |
| rd_data | output | CW | Registered counter value |

## Verification
The bench builds the block with two contexts, two sets per first-level side, two first-level ways, a four-way second level with two sets and 4-bit counters. With only two sets, a few line addresses are enough to force conflict misses, full-set evictions and a specific four-way tree victim order whose effects show up in the second-level miss and eviction counts. The 4-bit counters let the reference counter reach its saturation value within a few dozen references.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  // per-context counter slots
  localparam int SLOT_IHIT  = 0;
  localparam int SLOT_IMISS = 1;
  localparam int SLOT_DHIT  = 2;
  localparam int SLOT_DMISS = 3;
  localparam int SLOTS_PER_CTX = 4;
  // global counter slots, placed after all per-context slots
  localparam int G_REFS    = 0;
  localparam int G_L1I_EV  = 1;
  localparam int G_L1D_EV  = 2;
  localparam int G_L2_HIT  = 3;
  localparam int G_L2_MISS = 4;
  localparam int G_L2_EV   = 5;
  localparam int N_GLOBAL  = 6;
endpackage

// File: rtl/tsm_sat_counter.sv
module tsm_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc && (q != {W{1'b1}})) q <= q + 1'b1;
  end
endmodule

// File: rtl/tsm_tag_store.sv
module tsm_tag_store #(
  parameter int WAYS    = 2,
  parameter int ENTRIES = 64,
  parameter int TAGW    = 20,
  localparam int LOGW   = $clog2(WAYS),
  localparam int IDXW   = $clog2(ENTRIES),
  localparam int NODES  = WAYS - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_v,
  input  logic [IDXW-1:0] req_idx,
  input  logic [TAGW-1:0] req_tag,
  output logic            hit,
  output logic            miss,
  output logic            evict
);
  logic [WAYS-1:0]  vld  [ENTRIES];
  logic [NODES-1:0] tree [ENTRIES];
  logic [TAGW-1:0]  tag_rd [WAYS];

  logic [WAYS-1:0]  hit_vec;
  logic             hit_any, have_inv;
  logic [LOGW-1:0]  hit_way, inv_way, vict, acc_way;
  logic [NODES-1:0] tree_nxt;

  function automatic logic [LOGW-1:0] tree_pick(input logic [NODES-1:0] t);
    int n;
    n = 1;
    for (int l = 0; l < LOGW; l++) n = 2 * n + int'(t[n-1]);
    return LOGW'(n - WAYS);
  endfunction

  function automatic logic [NODES-1:0] tree_touch(input logic [NODES-1:0] t,
                                                  input logic [LOGW-1:0] w);
    logic [NODES-1:0] r;
    int n;
    r = t;
    n = 1;
    for (int l = 0; l < LOGW; l++) begin
      logic b;
      b = w[LOGW-1-l];
      r[n-1] = ~b;
      n = 2 * n + int'(b);
    end
    return r;
  endfunction

  // one tag memory per way, written on fill only
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAGW-1:0] mem [ENTRIES];
    always_ff @(posedge clk) begin
      if (req_v && !hit_any && (vict == LOGW'(w))) mem[req_idx] <= req_tag;
    end
    assign tag_rd[w]  = mem[req_idx];
    assign hit_vec[w] = vld[req_idx][w] && (tag_rd[w] == req_tag);
  end

  always_comb begin
    hit_any  = |hit_vec;
    hit_way  = '0;
    inv_way  = '0;
    have_inv = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = LOGW'(w);
      if (!vld[req_idx][w]) begin
        inv_way  = LOGW'(w);
        have_inv = 1'b1;
      end
    end
    vict     = have_inv ? inv_way : tree_pick(tree[req_idx]);
    acc_way  = hit_any ? hit_way : vict;
    tree_nxt = tree_touch(tree[req_idx], acc_way);
  end

  assign hit   = req_v && hit_any;
  assign miss  = req_v && !hit_any;
  assign evict = req_v && !hit_any && !have_inv;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) begin
        vld[e]  <= '0;
        tree[e] <= '0;
      end
    end else if (req_v) begin
      tree[req_idx] <= tree_nxt;
      if (!hit_any) vld[req_idx][vict] <= 1'b1;
    end
  end
endmodule

// File: rtl/trace_cache_stats.sv
module trace_cache_stats #(
  parameter int CTX_W   = 4,
  parameter int ADDR_W  = 40,
  parameter int LINE_B  = 64,
  parameter int L1_SETS = 64,
  parameter int L1_WAYS = 2,
  parameter int L2_SETS = 512,
  parameter int L2_WAYS = 8,
  parameter int CW      = 32,
  parameter int RD_AW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_valid,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic              ref_instr,
  input  logic              ref_write,
  input  logic [CTX_W-1:0]  ref_ctx,
  input  logic              clr_stats,
  input  logic [RD_AW-1:0]  rd_addr,
  output logic [CW-1:0]     rd_data
);
  import tsm_pkg::*;

  localparam int NCTX  = 1 << CTX_W;
  localparam int OFFB  = $clog2(LINE_B);
  localparam int L1IB  = $clog2(L1_SETS);
  localparam int L2IB  = $clog2(L2_SETS);
  localparam int L1TW  = ADDR_W - OFFB - L1IB;
  localparam int L2TW  = ADDR_W - OFFB - L2IB;
  localparam int LNW   = ADDR_W - OFFB;
  localparam int L1E   = NCTX * L1_SETS;
  localparam int GB    = SLOTS_PER_CTX * NCTX;
  localparam int NSTAT = GB + N_GLOBAL;
  localparam int SAW   = $clog2(NSTAT);

  // first level: index is {context, set}
  logic [CTX_W+L1IB-1:0] l1_idx;
  logic [L1TW-1:0]       l1_tag;
  logic i_hit, i_miss, i_evict, d_hit, d_miss, d_evict;
  logic l1_hit, l1_miss;

  assign l1_idx = {ref_ctx, ref_addr[OFFB+L1IB-1:OFFB]};
  assign l1_tag = ref_addr[ADDR_W-1:OFFB+L1IB];

  tsm_tag_store #(.WAYS(L1_WAYS), .ENTRIES(L1E), .TAGW(L1TW)) u_l1i (
    .clk(clk), .rst(rst), .req_v(ref_valid && ref_instr),
    .req_idx(l1_idx), .req_tag(l1_tag),
    .hit(i_hit), .miss(i_miss), .evict(i_evict));

  tsm_tag_store #(.WAYS(L1_WAYS), .ENTRIES(L1E), .TAGW(L1TW)) u_l1d (
    .clk(clk), .rst(rst), .req_v(ref_valid && !ref_instr),
    .req_idx(l1_idx), .req_tag(l1_tag),
    .hit(d_hit), .miss(d_miss), .evict(d_evict));

  assign l1_hit  = i_hit || d_hit;
  assign l1_miss = i_miss || d_miss;

  // miss forwarding register into the shared level
  logic           l2_v;
  logic [LNW-1:0] l2_line;
  logic           l2_hit, l2_miss, l2_evict;

  always_ff @(posedge clk) begin
    if (rst) l2_v <= 1'b0;
    else     l2_v <= ref_valid && l1_miss;
    l2_line <= ref_addr[ADDR_W-1:OFFB];
  end

  tsm_tag_store #(.WAYS(L2_WAYS), .ENTRIES(L2_SETS), .TAGW(L2TW)) u_l2 (
    .clk(clk), .rst(rst), .req_v(l2_v),
    .req_idx(l2_line[L2IB-1:0]), .req_tag(l2_line[LNW-1:L2IB]),
    .hit(l2_hit), .miss(l2_miss), .evict(l2_evict));

  // counter increments
  logic [NSTAT-1:0] inc;
  always_comb begin
    inc = '0;
    for (int c = 0; c < NCTX; c++) begin
      if (ref_ctx == CTX_W'(c)) begin
        inc[c*SLOTS_PER_CTX+SLOT_IHIT]  = i_hit;
        inc[c*SLOTS_PER_CTX+SLOT_IMISS] = i_miss;
        inc[c*SLOTS_PER_CTX+SLOT_DHIT]  = d_hit;
        inc[c*SLOTS_PER_CTX+SLOT_DMISS] = d_miss;
      end
    end
    inc[GB+G_REFS]    = ref_valid;
    inc[GB+G_L1I_EV]  = i_evict;
    inc[GB+G_L1D_EV]  = d_evict;
    inc[GB+G_L2_HIT]  = l2_hit;
    inc[GB+G_L2_MISS] = l2_miss;
    inc[GB+G_L2_EV]   = l2_evict;
  end

  logic [CW-1:0] cnt [NSTAT];
  for (genvar s = 0; s < NSTAT; s++) begin : g_cnt
    tsm_sat_counter #(.W(CW)) u_cnt (
      .clk(clk), .rst(rst), .clr(clr_stats), .inc(inc[s]), .q(cnt[s]));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_addr < RD_AW'(NSTAT)) rd_data <= cnt[rd_addr[SAW-1:0]];
    else rd_data <= '0;
  end

  // offset bits and the write flag do not affect a tag-only model
  logic unused_bits;
  assign unused_bits = ^{ref_addr[OFFB-1:0], ref_write};
endmodule

// File: rtl/trace_cache_stats_chk.sv
module trace_cache_stats_chk #(
  parameter int CW    = 32,
  parameter int RD_AW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_valid,
  input logic             l1_hit,
  input logic             l1_miss,
  input logic             i_evict,
  input logic             d_evict,
  input logic             l2_v,
  input logic             l2_hit,
  input logic             l2_miss,
  input logic             l2_evict,
  input logic             clr_stats,
  input logic [RD_AW-1:0] rd_addr,
  input logic [CW-1:0]    rd_data
);
  AST_L1_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    ref_valid |-> $countones({l1_hit, l1_miss}) == 1); // R2
  AST_L1_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ref_valid |-> !l1_hit && !l1_miss); // R2
  AST_L1_EVICT_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    (i_evict || d_evict) |-> l1_miss); // R3
  AST_MISS_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (ref_valid && l1_miss) |=> l2_v); // R5
  AST_HIT_NO_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (ref_valid && l1_hit) |=> !l2_v); // R5
  AST_L2_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    l2_v |-> $countones({l2_hit, l2_miss}) == 1); // R5
  AST_L2_EVICT_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    l2_evict |-> l2_miss); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    ($stable(rd_addr) && ($past(rd_addr, 2) == rd_addr) && !clr_stats
     && !$past(clr_stats) && !$past(clr_stats, 2))
    |-> rd_data >= $past(rd_data)); // R7
endmodule

bind trace_cache_stats trace_cache_stats_chk #(.CW(CW), .RD_AW(RD_AW)) u_chk (
  .clk(clk), .rst(rst), .ref_valid(ref_valid), .l1_hit(l1_hit),
  .l1_miss(l1_miss), .i_evict(i_evict), .d_evict(d_evict), .l2_v(l2_v),
  .l2_hit(l2_hit), .l2_miss(l2_miss), .l2_evict(l2_evict),
  .clr_stats(clr_stats), .rd_addr(rd_addr), .rd_data(rd_data));

// File: tb/sim_trace_cache_stats.sv
`timescale 1ns/1ps
module sim_trace_cache_stats;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_valid = 1'b0;
  logic [15:0] ref_addr = '0;
  logic        ref_instr = 1'b0;
  logic        ref_write = 1'b0;
  logic [0:0]  ref_ctx = '0;
  logic        clr_stats = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [3:0]  rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trace_cache_stats #(.CTX_W(1), .ADDR_W(16), .LINE_B(64), .L1_SETS(2),
    .L1_WAYS(2), .L2_SETS(2), .L2_WAYS(4), .CW(4), .RD_AW(8)) u0 (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_addr(ref_addr),
    .ref_instr(ref_instr), .ref_write(ref_write), .ref_ctx(ref_ctx),
    .clr_stats(clr_stats), .rd_addr(rd_addr), .rd_data(rd_data));

  // counter addresses: ctx*4+k, globals from 8
  localparam int A_REFS = 8, A_IEV = 9, A_DEV = 10, A_L2H = 11, A_L2M = 12, A_L2E = 13;

  // {instr, ctx, write, addr[15:0], expected L1 hit}
  localparam logic [19:0] VEC [13] = '{
    {1'b0, 1'b0, 1'b0, 16'h0000, 1'b0},
    {1'b0, 1'b0, 1'b0, 16'h0000, 1'b1},
    {1'b0, 1'b0, 1'b0, 16'h0080, 1'b0},
    {1'b0, 1'b0, 1'b0, 16'h0000, 1'b1},
    {1'b0, 1'b0, 1'b0, 16'h0100, 1'b0},
    {1'b0, 1'b0, 1'b0, 16'h0000, 1'b1},
    {1'b0, 1'b0, 1'b0, 16'h0080, 1'b0},
    {1'b0, 1'b1, 1'b0, 16'h0000, 1'b0},
    {1'b1, 1'b0, 1'b0, 16'h0000, 1'b0},
    {1'b1, 1'b0, 1'b0, 16'h0000, 1'b1},
    {1'b0, 1'b0, 1'b0, 16'h003F, 1'b1},
    {1'b0, 1'b0, 1'b0, 16'h0040, 1'b0},
    {1'b0, 1'b0, 1'b1, 16'h0080, 1'b1}
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_ref(input bit instr, input bit ctx, input bit wr, input logic [15:0] a);
    @(negedge clk);
    ref_valid = 1'b1; ref_instr = instr; ref_ctx = ctx; ref_write = wr; ref_addr = a;
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = 8'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic rd_check(input string req, input int a, input int exp);
    int v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2: watchdog expired, got hung expected finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int expv [8];
    int idx;
    for (int i = 0; i < 8; i++) expv[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9: all counters zero after reset
    for (int a = 0; a < 14; a++) rd_check("R9 reset counter", a, 0);

    // R1 R2 R3 R4 R6: table of references with expected L1 outcome
    for (int i = 0; i < 13; i++) begin
      do_ref(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:1]);
      idx = int'(VEC[i][18]) * 4 + (VEC[i][19] ? 0 : 2) + (VEC[i][0] ? 0 : 1);
      expv[idx]++;
      rd_check(VEC[i][17] ? "R6 write outcome" : "R1 hit/miss outcome", idx, expv[idx]);
    end
    rd_check("R2 reference count", A_REFS, 13);
    rd_check("R3 data-side evictions", A_DEV, 2);
    rd_check("R3 instr-side evictions", A_IEV, 0);
    rd_check("R5 second-level hits", A_L2H, 3);
    rd_check("R5 second-level misses", A_L2M, 4);
    rd_check("R5 second-level evictions", A_L2E, 0);

    // R4: tree victim order in the four-way shared level
    do_ref(1'b0, 1'b0, 1'b0, 16'h0180);
    do_ref(1'b0, 1'b0, 1'b0, 16'h0200);
    do_ref(1'b0, 1'b1, 1'b0, 16'h0080);
    do_ref(1'b0, 1'b1, 1'b0, 16'h0100);
    do_ref(1'b1, 1'b1, 1'b0, 16'h0000);
    rd_check("R4 second-level misses after victims", A_L2M, 9);
    rd_check("R4 second-level evictions", A_L2E, 4);
    do_ref(1'b0, 1'b1, 1'b0, 16'h0200);
    rd_check("R4 survivor hits in second level", A_L2H, 4);
    rd_check("R3 data-side evictions after fills", A_DEV, 6);
    rd_check("R2 ctx0 data misses", 3, 7);
    rd_check("R2 ctx1 data misses", 7, 4);
    rd_check("R1 ctx1 instr misses", 5, 1);
    rd_check("R7 reference count saturates", A_REFS, 15);

    // R8: clear keeps tags
    @(negedge clk); clr_stats = 1'b1;
    @(negedge clk); clr_stats = 1'b0;
    for (int a = 0; a < 14; a++) rd_check("R8 cleared counter", a, 0);
    do_ref(1'b0, 1'b0, 1'b0, 16'h0200);
    rd_check("R8 tag kept after clear", 2, 1);
    rd_check("R8 no miss after clear", 3, 0);

    // R9: reset invalidates lines
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    do_ref(1'b0, 1'b0, 1'b0, 16'h0200);
    rd_check("R9 miss after reset", 3, 1);
    rd_check("R9 hit count after reset", 2, 0);

    // R10: out-of-range reads
    rd_check("R10 address past map", 14, 0);
    rd_check("R10 high address", 200, 0);
    // R10: one-cycle latency
    @(negedge clk); rd_addr = 8'(A_REFS);
    @(negedge clk); check("R10 read latency", int'(rd_data), 1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule